// File: doc/BRIEF.md
# Execute Stage with Poison Marking

This block is the execute stage of an in-order pipeline. Each cycle it may take one operand bundle from the register-read queue. The bundle carries an instruction class, an operation code, a destination register, a write-enable flag, two source operands, an immediate, and a one-bit epoch tag. The stage compares that tag with its own epoch register. A match means the instruction is live. It is then executed by a small ALU, resolved as a branch, or turned into a memory address. A mismatch means the instruction lies on a squashed path. It is not dropped: it is passed on with a poison flag, so that later stages still release its scoreboard entry.

Live ALU instructions that write a register place their destination and result on a bypass output back to register read. A live branch that resolves as taken emits a redirect to its target and flips the epoch. Every instruction fetched after the redirect then arrives with the new tag, and everything still in flight from the old path is poisoned. Taking an entry from the input and pushing a bundle to the output always happen together. When the output queue is full the stage holds.

Top module: `exec_stage`

## Requirements
- R1: After reset the epoch is 0. With no valid input, out_enq, in_deq, byp_valid and redir_valid are all low.
- R2: When in_valid is high and out_full is low, in_deq and out_enq are both high in that same cycle.
- R3: When out_full is high, in_deq, out_enq, byp_valid and redir_valid are low, and the epoch does not change at the next clock edge.
- R4: A forwarded bundle has out_poison high exactly when in_epoch differs from the current epoch. out_kind, out_dst and out_wen are copies of the input.
- R5: For a live ALU instruction (kind 0), out_data is selected by op: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 signed less-than (value 1 or 0), 6 shift left by src2[4:0], 7 logical shift right by src2[4:0].
- R6: A poisoned bundle has out_data and out_addr zero. It never drives the bypass and never causes a redirect.
- R7: byp_valid is high only for a forwarded, live ALU instruction with in_wen set. byp_dst and byp_data then equal the destination and the ALU result.
- R8: A live branch (kind 1) is taken according to op[1:0]: 0 equal, 1 not equal, 2 signed less-than, 3 always. When taken, redir_valid is high and redir_pc equals in_imm. out_addr carries in_imm for any live branch, and out_data is zero.
- R9: The epoch flips at the clock edge that ends a cycle with redir_valid high. In every other cycle it holds.
- R10: A live memory instruction (kind 2) has out_addr = src1 + imm and out_data = src2, and no bypass. A live no-op (kind 3) has out_data and out_addr zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input queue holds a bundle |
| in_epoch | input | 1 | Epoch tag of the input bundle |
| in_kind | input | 2 | Class: 0 ALU, 1 branch, 2 memory, 3 no-op |
| in_op | input | 3 | ALU operation or branch condition |
| in_dst | input | REG_W | Destination register |
| in_wen | input | 1 | Instruction writes a register |
| in_src1 | input | DATA_W | First operand |
| in_src2 | input | DATA_W | Second operand |
| in_imm | input | DATA_W | Immediate or branch target |
| in_deq | output | 1 | Take the head of the input queue |
| out_full | input | 1 | Output queue cannot accept |
| out_enq | output | 1 | Push the result bundle |
| out_poison | output | 1 | Bundle is from a squashed path |
| out_kind | output | 2 | Class, copied |
| out_dst | output | REG_W | Destination, copied |
| out_wen | output | 1 | Write flag, copied |
| out_data | output | DATA_W | Result or store data |
| out_addr | output | DATA_W | Memory address or branch target |
| byp_valid | output | 1 | Bypass value present |
| byp_dst | output | REG_W | Bypass destination |
| byp_data | output | DATA_W | Bypass value |
| redir_valid | output | 1 | Taken branch redirect |
| redir_pc | output | DATA_W | Redirect target |
| cur_epoch | output | 1 | Current epoch |

## Verification
The hardest case is a stream of instructions that are still in flight after a taken branch, carrying the stale tag. Among them is a poisoned taken branch, which must neither redirect nor flip the epoch. The driver keeps its own model of the epoch. It can tag each instruction as live or stale against that model, so the bench sends back-to-back stale ALU writes, stale branches and stale memory operations right after a redirect. Once the epoch has flipped, it sends live work again. It also holds the output full while a taken branch is waiting. This shows that a stalled branch leaves the epoch alone.

// File: rtl/ex_pkg.sv
package ex_pkg;
  typedef enum logic [1:0] {
    K_ALU = 2'd0,
    K_BR  = 2'd1,
    K_MEM = 2'd2,
    K_NOP = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SLT = 3'd5,
    OP_SLL = 3'd6,
    OP_SRL = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    BC_EQ  = 2'd0,
    BC_NE  = 2'd1,
    BC_LT  = 2'd2,
    BC_ALW = 2'd3
  } br_cond_e;
endpackage

// File: rtl/ex_alu.sv
module ex_alu #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  import ex_pkg::*;
  localparam int SHAMT_W = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] alu_calc(
    input alu_op_e f, input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] z);
    logic [SHAMT_W-1:0] sh;
    sh = z[SHAMT_W-1:0];
    case (f)
      OP_ADD:  return x + z;
      OP_SUB:  return x - z;
      OP_AND:  return x & z;
      OP_OR:   return x | z;
      OP_XOR:  return x ^ z;
      OP_SLT:  return {{(DATA_W-1){1'b0}}, ($signed(x) < $signed(z))};
      OP_SLL:  return x << sh;
      default: return x >> sh;
    endcase
  endfunction

  always_comb y = alu_calc(alu_op_e'(op), a, b);
endmodule

// File: rtl/ex_branch.sv
module ex_branch #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        cond,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              taken
);
  import ex_pkg::*;

  function automatic logic resolve(
    input br_cond_e c, input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] z);
    case (c)
      BC_EQ:   return x == z;
      BC_NE:   return x != z;
      BC_LT:   return $signed(x) < $signed(z);
      default: return 1'b1;
    endcase
  endfunction

  always_comb taken = resolve(br_cond_e'(cond), a, b);
endmodule

// File: rtl/ex_epoch.sv
module ex_epoch (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic epoch
);
  always_ff @(posedge clk) begin
    if (!rst_n)    epoch <= 1'b0;
    else if (flip) epoch <= ~epoch;
  end
endmodule

// File: rtl/exec_stage.sv
module exec_stage #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_epoch,
  input  logic [1:0]        in_kind,
  input  logic [2:0]        in_op,
  input  logic [REG_W-1:0]  in_dst,
  input  logic              in_wen,
  input  logic [DATA_W-1:0] in_src1,
  input  logic [DATA_W-1:0] in_src2,
  input  logic [DATA_W-1:0] in_imm,
  output logic              in_deq,
  input  logic              out_full,
  output logic              out_enq,
  output logic              out_poison,
  output logic [1:0]        out_kind,
  output logic [REG_W-1:0]  out_dst,
  output logic              out_wen,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W-1:0] out_addr,
  output logic              byp_valid,
  output logic [REG_W-1:0]  byp_dst,
  output logic [DATA_W-1:0] byp_data,
  output logic              redir_valid,
  output logic [DATA_W-1:0] redir_pc,
  output logic              cur_epoch
);
  import ex_pkg::*;

  // named internal events
  logic              fire;
  logic              live;
  logic              br_taken;
  logic              epoch_flip;
  logic [DATA_W-1:0] alu_y;
  kind_e             kind;

  function automatic logic [DATA_W-1:0] agen(
    input logic [DATA_W-1:0] base, input logic [DATA_W-1:0] ofs);
    return base + ofs;
  endfunction

  assign kind = kind_e'(in_kind);
  assign fire = in_valid && !out_full;
  assign live = (in_epoch == cur_epoch);

  ex_alu #(.DATA_W(DATA_W)) u_alu (
    .op(in_op), .a(in_src1), .b(in_src2), .y(alu_y));

  ex_branch #(.DATA_W(DATA_W)) u_br (
    .cond(in_op[1:0]), .a(in_src1), .b(in_src2), .taken(br_taken));

  assign epoch_flip = fire && live && (kind == K_BR) && br_taken;

  ex_epoch u_epoch (
    .clk(clk), .rst_n(rst_n), .flip(epoch_flip), .epoch(cur_epoch));

  // handshake: dequeue and enqueue move together
  assign in_deq  = fire;
  assign out_enq = fire;

  // bundle fields carried for downstream bookkeeping
  assign out_poison = !live;
  assign out_kind   = in_kind;
  assign out_dst    = in_dst;
  assign out_wen    = in_wen;

  always_comb begin
    out_data = '0;
    out_addr = '0;
    if (live) begin
      case (kind)
        K_ALU:   out_data = alu_y;
        K_BR:    out_addr = in_imm;
        K_MEM: begin
          out_data = in_src2;
          out_addr = agen(in_src1, in_imm);
        end
        default: ;
      endcase
    end
  end

  // bypass back to register read
  assign byp_valid = fire && live && (kind == K_ALU) && in_wen;
  assign byp_dst   = in_dst;
  assign byp_data  = alu_y;

  // redirect
  assign redir_valid = epoch_flip;
  assign redir_pc    = in_imm;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_full |-> (!in_deq && !out_enq && !byp_valid && !redir_valid)) else $error("stall"); // R3
  AST_DEQ_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    in_deq == out_enq) else $error("deq/enq"); // R2
  AST_POISON_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_enq && out_poison) |-> (!byp_valid && !redir_valid)) else $error("poison side effect"); // R6
  AST_BYPASS_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    byp_valid |-> (out_enq && out_wen && out_kind == 2'd0 && byp_data == out_data)) else $error("bypass"); // R7
  AST_EPOCH_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (cur_epoch != $past(cur_epoch))) else $error("flip"); // R9
  AST_EPOCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid |=> $stable(cur_epoch)) else $error("hold"); // R9
endmodule

// File: tb/sim_exec_stage.sv
module sim_exec_stage;
  localparam int DW = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          in_valid = 0, in_epoch = 0, in_wen = 0, out_full = 0;
  logic [1:0]    in_kind = 0;
  logic [2:0]    in_op = 0;
  logic [RW-1:0] in_dst = 0;
  logic [DW-1:0] in_src1 = 0, in_src2 = 0, in_imm = 0;
  logic          in_deq, out_enq, out_poison, out_wen, byp_valid, redir_valid, cur_epoch;
  logic [1:0]    out_kind;
  logic [RW-1:0] out_dst, byp_dst;
  logic [DW-1:0] out_data, out_addr, byp_data, redir_pc;

  exec_stage #(.DATA_W(DW), .REG_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_epoch(in_epoch),
    .in_kind(in_kind), .in_op(in_op), .in_dst(in_dst), .in_wen(in_wen),
    .in_src1(in_src1), .in_src2(in_src2), .in_imm(in_imm), .in_deq(in_deq),
    .out_full(out_full), .out_enq(out_enq), .out_poison(out_poison),
    .out_kind(out_kind), .out_dst(out_dst), .out_wen(out_wen),
    .out_data(out_data), .out_addr(out_addr), .byp_valid(byp_valid),
    .byp_dst(byp_dst), .byp_data(byp_data), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .cur_epoch(cur_epoch));

  typedef struct {
    logic          poison;
    logic [1:0]    kind;
    logic [RW-1:0] dst;
    logic          wen;
    logic [DW-1:0] data;
    logic [DW-1:0] addr;
    logic          byp;
    logic          redir;
    logic [DW-1:0] target;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  logic m_epoch = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_alu(input logic [2:0] op,
      input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] r;
    case (op)
      3'd0: r = a + b;
      3'd1: r = a + (~b) + 1;
      3'd2: r = ~(~a | ~b);
      3'd3: r = ~(~a & ~b);
      3'd4: r = (a | b) & ~(a & b);
      3'd5: r = ($signed(a) < $signed(b)) ? 1 : 0;
      3'd6: r = a << b[4:0];
      default: r = a >> b[4:0];
    endcase
    return r;
  endfunction

  function automatic logic ref_taken(input logic [1:0] c,
      input logic [DW-1:0] a, input logic [DW-1:0] b);
    if (c == 2'd0) return a == b;
    if (c == 2'd1) return a != b;
    if (c == 2'd2) return $signed(a) < $signed(b);
    return 1'b1;
  endfunction

  // driver: one instruction per cycle, expected bundle pushed to scoreboard
  task automatic send(input logic [1:0] k, input logic [2:0] op,
      input logic [RW-1:0] d, input logic w, input logic [DW-1:0] a,
      input logic [DW-1:0] b, input logic [DW-1:0] imm, input bit is_live);
    exp_t e;
    @(negedge clk);
    #1;
    chk(cur_epoch == m_epoch, "R9", "epoch before issue", cur_epoch, m_epoch);
    in_valid = 1; in_kind = k; in_op = op; in_dst = d; in_wen = w;
    in_src1 = a; in_src2 = b; in_imm = imm;
    in_epoch = is_live ? m_epoch : ~m_epoch;
    e.poison = !is_live; e.kind = k; e.dst = d; e.wen = w;
    e.data = '0; e.addr = '0; e.byp = 0; e.redir = 0; e.target = imm;
    if (is_live) begin
      if (k == 2'd0) begin
        e.data = ref_alu(op, a, b);
        e.byp  = w;
      end else if (k == 2'd1) begin
        e.addr  = imm;
        e.redir = ref_taken(op[1:0], a, b);
      end else if (k == 2'd2) begin
        e.data = b;
        e.addr = a + imm;
      end
    end
    q.push_back(e);
    if (e.redir) m_epoch = ~m_epoch;
  endtask

  task automatic idle();
    @(negedge clk);
    #1;
    in_valid = 0;
  endtask

  // monitor: pops and compares when the stage enqueues
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n && out_enq) begin
        if (q.size() == 0) begin
          chk(0, "R2", "unexpected enqueue", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(in_deq, "R2", "deq with enq", in_deq, 1);
          chk(out_poison == e.poison, "R4", "poison", out_poison, e.poison);
          chk(out_kind == e.kind && out_dst == e.dst && out_wen == e.wen, "R4",
              "kind/dst/wen", {out_kind, out_dst, out_wen}, {e.kind, e.dst, e.wen});
          chk(out_data == e.data, e.poison ? "R6" : (e.kind == 0 ? "R5" : "R10"),
              "data", out_data, e.data);
          chk(out_addr == e.addr, e.poison ? "R6" : (e.kind == 1 ? "R8" : "R10"),
              "addr", out_addr, e.addr);
          chk(byp_valid == e.byp, "R7", "bypass valid", byp_valid, e.byp);
          if (e.byp)
            chk(byp_dst == e.dst && byp_data == e.data, "R7", "bypass payload",
                byp_data, e.data);
          chk(redir_valid == e.redir, "R8", "redirect", redir_valid, e.redir);
          if (e.redir)
            chk(redir_pc == e.target, "R8", "redirect target", redir_pc, e.target);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #3;
    // R1 reset state
    chk(cur_epoch == 0, "R1", "reset epoch", cur_epoch, 0);
    chk(!out_enq && !in_deq && !byp_valid && !redir_valid, "R1", "idle outputs",
        {out_enq, in_deq, byp_valid, redir_valid}, 0);

    // R5 all ALU ops, live
    send(0, 0, 5'd1, 1, 32'd7, 32'd9, 0, 1);
    send(0, 1, 5'd2, 1, 32'd3, 32'd10, 0, 1);
    send(0, 2, 5'd3, 1, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 1);
    send(0, 3, 5'd4, 1, 32'hF000_0001, 32'h000F_0010, 0, 1);
    send(0, 4, 5'd5, 1, 32'hAAAA_5555, 32'hFFFF_0000, 0, 1);
    send(0, 5, 5'd6, 1, 32'hFFFF_FFFE, 32'd1, 0, 1);
    send(0, 5, 5'd6, 1, 32'd4, 32'hFFFF_FFFF, 0, 1);
    send(0, 6, 5'd7, 1, 32'h0000_0003, 32'h0000_0124, 0, 1);
    send(0, 7, 5'd8, 0, 32'h8000_0000, 32'd31, 0, 1);   // R7 no wen, no bypass
    // R10 memory and no-op
    send(2, 0, 5'd9, 1, 32'h1000, 32'hDEAD_BEEF, 32'h24, 1);
    send(3, 0, 5'd0, 0, 32'h55, 32'h66, 32'h77, 1);
    // R8 untaken branches
    send(1, 0, 5'd0, 0, 32'd1, 32'd2, 32'h400, 1);
    send(1, 1, 5'd0, 0, 32'd5, 32'd5, 32'h404, 1);
    send(1, 2, 5'd0, 0, 32'd5, 32'hFFFF_FFFF, 32'h408, 1);
    // R8 R9 taken branch, then shadow of stale instructions (R4 R6)
    send(1, 2, 5'd0, 0, 32'hFFFF_FFF0, 32'd3, 32'h800, 1);
    send(0, 0, 5'd1, 1, 32'd1, 32'd1, 0, 0);
    send(1, 3, 5'd0, 0, 0, 0, 32'hBAD0, 0);            // poisoned jump
    send(2, 0, 5'd3, 0, 32'h10, 32'h20, 32'h4, 0);
    send(0, 4, 5'd4, 1, 32'hF, 32'h3, 0, 1);           // live on new epoch
    send(1, 3, 5'd0, 0, 0, 0, 32'h1200, 1);            // jump, flip back
    send(1, 0, 5'd0, 0, 32'd9, 32'd9, 32'h1300, 1);    // taken eq, flip again
    send(0, 1, 5'd5, 1, 32'd0, 32'd1, 0, 1);
    idle();

    // R3 stall with a live taken branch waiting
    @(negedge clk);
    #1;
    out_full = 1; in_valid = 1; in_kind = 1; in_op = 3; in_imm = 32'h2000;
    in_epoch = m_epoch; in_wen = 0;
    #2;
    chk(!in_deq && !out_enq && !byp_valid && !redir_valid, "R3", "stall outputs",
        {in_deq, out_enq, byp_valid, redir_valid}, 0);
    @(negedge clk);
    #1;
    chk(cur_epoch == m_epoch, "R3", "epoch held during stall", cur_epoch, m_epoch);
    in_kind = 0; in_op = 0; in_wen = 1; in_dst = 5'd3;
    #2;
    chk(!byp_valid && !out_enq, "R3", "no bypass while full", byp_valid, 0);
    @(negedge clk);
    #1;
    out_full = 0; in_valid = 0;
    send(0, 0, 5'd6, 1, 32'd100, 32'd23, 0, 1);        // R2 resumes
    idle();
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule